// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is a single DMA channel that walks a chain of transfer descriptors held in memory. Software writes the descriptors, then pulses `start` with the address of the first one. The channel reads the four descriptor words through its memory master port. It then moves the programmed number of bytes from the source address to the target address, one element per read/write pair, and follows the link word to the next descriptor. The chain ends on a descriptor whose link carries the stop flag. A chain whose last link points back to an earlier descriptor runs as an endless ring.

Each descriptor is 32-byte aligned and holds four little-endian words at offsets 0, 4, 8 and 12: the link, the source address, the target address and the command. The command word selects address increments, peripheral pacing, start and end events, byte reversal, burst size, element width and a 13-bit byte length. The live source and target addresses are visible on output ports, so a status unit can work out how many bytes remain. Events go to a separate status unit as single-cycle pulses.

Top module: `dma_desc_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req` and all four event outputs are low.
- R2: A `start` pulse while idle fetches the four descriptor words from `{start_addr[31:4],4'h0}` plus 0, 4, 8 and 12, in the order link, source, target, command. The low four bits of `start_addr` are ignored.
- R3: Command bit 31 advances the source address and bit 30 advances the target address by the element size after each element. Width field [15:14] gives element bytes 3→4, 2→2, 1 or 0→1. The last element of a descriptor is cut to the bytes remaining, and `mem_size` carries the element byte count (4 for descriptor reads).
- R4: Command bits [12:0] are the byte length. A length of zero makes no data access and goes straight to the link step.
- R5: Link bit 0 set halts the channel after the descriptor and pulses `ev_stop`. Otherwise the next descriptor is fetched from `{link[31:4],4'h0}`, so a link back to an earlier descriptor loops without end.
- R6: `ev_start` pulses once per descriptor loaded with command bit 22 set. `ev_end` pulses once per descriptor completed with command bit 21 set.
- R7: When command bit 29 or 28 is set, each burst starts only while `periph_req` is high. Burst bytes come from field [17:16]: 3→32, 2→16, 1 or 0→8. With both bits clear, no wait is made.
- R8: Command bit 18 reverses the byte order of each element's bytes on the write.
- R9: A response with `mem_err` high halts the channel at once, pulses `ev_buserr`, issues no further access and gives no `ev_end`.
- R10: A `start` pulse while the channel is busy is ignored.
- R11: `cur_src` and `cur_trg` show the live source and target addresses. After a descriptor they equal its start values plus the length for each incrementing side.
- R12: A request holds `mem_req`, `mem_we` and `mem_addr` steady until the cycle that `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a chain (idle only) |
| start_addr | input | 32 | Address of first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 3 | Bytes in the access, 1 to 4 |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| periph_req | input | 1 | Peripheral ready for one burst |
| busy | output | 1 | Channel is working a chain |
| ev_start | output | 1 | Descriptor-start event pulse |
| ev_end | output | 1 | Descriptor-end event pulse |
| ev_buserr | output | 1 | Bus error event pulse |
| ev_stop | output | 1 | Chain halted on stop flag |
| cur_src | output | 32 | Live source address |
| cur_trg | output | 32 | Live target address |

## Verification
The end event and the stop halt of a chain's last descriptor fall in the same cycle. Every stop-terminated run provokes both together, and the bench judges them by counting each pulse on its own. A bus error can strike while a ring is delivering end events back to back. This is provoked by poisoning one target address after several laps. It is judged by the bus-error count, by an unchanged end count and write count afterwards, and by a zero stop count.

// File: rtl/dma_desc_chan.sv
module dma_desc_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [2:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        periph_req,
  output logic        busy,
  output logic        ev_start,
  output logic        ev_end,
  output logic        ev_buserr,
  output logic        ev_stop,
  output logic [31:0] cur_src,
  output logic [31:0] cur_trg
);
  localparam int LEN_W = 13;
  localparam int BC_W  = 7;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_GATE, S_RD, S_WR, S_DONE} st_t;

  st_t              state;
  logic [31:0]      ptr, link, src, trg, cmd, data;
  logic [1:0]       widx;
  logic [LEN_W-1:0] rem;
  logic [BC_W-1:0]  bcnt;
  logic             r_start, r_end, r_err, r_stop;

  logic [2:0]      wbytes, eb;
  logic [BC_W-1:0] bbytes, bnext;
  logic [31:0]     swp;
  logic [1:0]      kk;
  logic            flow, ack_ok, ack_bad;
  logic            unused_bits;

  assign wbytes = (cmd[15:14] == 2'd3) ? 3'd4 : (cmd[15:14] == 2'd2) ? 3'd2 : 3'd1;
  assign eb     = (rem < LEN_W'(wbytes)) ? rem[2:0] : wbytes;
  assign bbytes = (cmd[17:16] == 2'd3) ? 7'd32 : (cmd[17:16] == 2'd2) ? 7'd16 : 7'd8;
  assign bnext  = bcnt + BC_W'(eb);
  assign flow   = cmd[29] | cmd[28];
  assign ack_ok  = mem_req & mem_ack & ~mem_err;
  assign ack_bad = mem_req & mem_ack & mem_err;
  assign unused_bits = ^{link[3:1], cmd[27:23], cmd[20:19], cmd[13]};

  always_comb begin
    swp = '0;
    kk  = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(eb)) begin
        kk = 2'(int'(eb) - 1 - i);
        swp[8*i +: 8] = data[{kk, 3'b000} +: 8];
      end
    end
  end

  assign mem_req   = (state == S_FETCH) || (state == S_RD) || (state == S_WR);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = (state == S_FETCH) ? ptr + {28'd0, widx, 2'b00} :
                     (state == S_RD)    ? src : trg;
  assign mem_size  = (state == S_FETCH) ? 3'd4 : eb;
  assign mem_wdata = cmd[18] ? swp : data;

  assign busy      = (state != S_IDLE);
  assign ev_start  = r_start;
  assign ev_end    = r_end;
  assign ev_buserr = r_err;
  assign ev_stop   = r_stop;
  assign cur_src   = src;
  assign cur_trg   = trg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ptr     <= '0;
      link    <= '0;
      src     <= '0;
      trg     <= '0;
      cmd     <= '0;
      data    <= '0;
      widx    <= '0;
      rem     <= '0;
      bcnt    <= '0;
      r_start <= 1'b0;
      r_end   <= 1'b0;
      r_err   <= 1'b0;
      r_stop  <= 1'b0;
    end else begin
      r_start <= 1'b0;
      r_end   <= 1'b0;
      r_err   <= 1'b0;
      r_stop  <= 1'b0;
      if (ack_bad) begin
        state <= S_IDLE;
        r_err <= 1'b1;
      end else begin
        case (state)
          S_IDLE: if (start) begin
            ptr   <= {start_addr[31:4], 4'h0};
            widx  <= '0;
            state <= S_FETCH;
          end
          S_FETCH: if (ack_ok) begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: link <= mem_rdata;
              2'd1: src  <= mem_rdata;
              2'd2: trg  <= mem_rdata;
              default: begin
                cmd     <= mem_rdata;
                rem     <= mem_rdata[LEN_W-1:0];
                bcnt    <= '0;
                r_start <= mem_rdata[22];
                state   <= (mem_rdata[LEN_W-1:0] == '0) ? S_DONE : S_GATE;
              end
            endcase
          end
          S_GATE: if (!flow || periph_req) begin
            bcnt  <= '0;
            state <= S_RD;
          end
          S_RD: if (ack_ok) begin
            data  <= mem_rdata;
            state <= S_WR;
          end
          S_WR: if (ack_ok) begin
            if (cmd[31]) src <= src + 32'(eb);
            if (cmd[30]) trg <= trg + 32'(eb);
            rem  <= rem - LEN_W'(eb);
            bcnt <= bnext;
            if (rem == LEN_W'(eb))  state <= S_DONE;
            else if (bnext >= bbytes) state <= S_GATE;
            else                      state <= S_RD;
          end
          S_DONE: begin
            r_end <= cmd[21];
            if (link[0]) begin
              r_stop <= 1'b1;
              state  <= S_IDLE;
            end else begin
              ptr   <= {link[31:4], 4'h0};
              widx  <= '0;
              state <= S_FETCH;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_desc_chan_chk.sv
module dma_desc_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic [2:0]  mem_size,
  input logic        periph_req,
  input logic        busy,
  input logic        ev_buserr,
  input logic        ev_stop,
  input logic [2:0]  st,
  input logic        flow
);
  localparam logic [2:0] ST_GATE = 3'd2;

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_err_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (!busy && ev_buserr));

  p_flow_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GATE && flow && !periph_req) |=> !mem_req);

  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |-> !busy);

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_size >= 3'd1 && mem_size <= 3'd4));
endmodule

bind dma_desc_chan dma_desc_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
  .mem_size(mem_size), .periph_req(periph_req), .busy(busy),
  .ev_buserr(ev_buserr), .ev_stop(ev_stop), .st(state),
  .flow(cmd[29] | cmd[28])
);

// File: tb/dma_desc_chan_tb.sv
`timescale 1ns/1ps
module dma_desc_chan_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, mem_req, mem_we, mem_ack, mem_err, periph_req;
  logic        busy, ev_start, ev_end, ev_buserr, ev_stop;
  logic [31:0] start_addr, mem_addr, mem_wdata, mem_rdata, cur_src, cur_trg;
  logic [2:0]  mem_size;

  dma_desc_chan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .periph_req(periph_req), .busy(busy), .ev_start(ev_start), .ev_end(ev_end),
    .ev_buserr(ev_buserr), .ev_stop(ev_stop), .cur_src(cur_src), .cur_trg(cur_trg)
  );

  logic [7:0]  mem [0:4095];
  logic [7:0]  expm [0:4095];
  int nchk = 0, nfail = 0;
  int nrd, nwr, n_start, n_end, n_err, n_stop, stable_bad = 0, lat = 0;
  logic        err_on = 1'b0, last_pend = 1'b0;
  logic [31:0] err_addr = '0, last_addr = '0;

  initial begin
    mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      if (rst_n) begin
        n_start += int'(ev_start); n_end += int'(ev_end);
        n_err += int'(ev_buserr); n_stop += int'(ev_stop);
      end
      if (rst_n && mem_req) begin
        if (last_pend && mem_addr != last_addr) stable_bad++;
        if (lat == 0) begin
          if (err_on && mem_addr == err_addr) mem_err = 1'b1;
          else if (mem_we) begin
            for (int i = 0; i < int'(mem_size); i++)
              mem[12'(mem_addr + 32'(i))] = mem_wdata[8*i +: 8];
            nwr++;
          end else begin
            for (int i = 0; i < 4; i++)
              mem_rdata[8*i +: 8] = mem[12'(mem_addr + 32'(i))];
            nrd++;
          end
          mem_ack = 1'b1;
          lat = $urandom_range(0, 2);
          last_pend = 1'b0;
        end else begin
          lat--;
          last_pend = 1'b1;
          last_addr = mem_addr;
        end
      end else last_pend = 1'b0;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic chk(string req, longint act, longint expv);
    nchk++;
    if (act != expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cmp_mem(string req);
    int bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic wr32(int a, logic [31:0] v);
    for (int i = 0; i < 4; i++) begin
      mem[12'(a + i)] = v[8*i +: 8];
      expm[12'(a + i)] = v[8*i +: 8];
    end
  endtask

  task automatic put_desc(int a, logic [31:0] lk, logic [31:0] s, logic [31:0] t, logic [31:0] c);
    wr32(a, lk); wr32(a + 4, s); wr32(a + 8, t); wr32(a + 12, c);
  endtask

  function automatic logic [31:0] mk(int len, int w, int b, bit is, bit it, bit fs, bit ft,
                                     bit si, bit ei, bit en);
    logic [31:0] c = '0;
    c[12:0] = 13'(len); c[15:14] = 2'(w); c[17:16] = 2'(b);
    c[31] = is; c[30] = it; c[29] = fs; c[28] = ft; c[22] = si; c[21] = ei; c[18] = en;
    return c;
  endfunction

  task automatic model(logic [31:0] s, logic [31:0] t, logic [31:0] c);
    int rem = int'(c[12:0]);
    int w = (c[15:14] == 2'd3) ? 4 : (c[15:14] == 2'd2) ? 2 : 1;
    while (rem > 0) begin
      int eb;
      logic [7:0] b [4];
      eb = (rem < w) ? rem : w;
      for (int i = 0; i < eb; i++) b[i] = expm[12'(s + 32'(i))];
      for (int i = 0; i < eb; i++) expm[12'(t + 32'(i))] = c[18] ? b[eb - 1 - i] : b[i];
      if (c[31]) s += 32'(eb);
      if (c[30]) t += 32'(eb);
      rem -= eb;
    end
  endtask

  task automatic clr();
    nrd = 0; nwr = 0; n_start = 0; n_end = 0; n_err = 0; n_stop = 0;
  endtask

  task automatic kick(logic [31:0] a);
    @(negedge clk); start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    if (t >= 20000) chk({req, " timeout"}, 1, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] c, c2, s, t;
    int ne, nw, exp_s, exp_e, tw;
    void'($urandom(32'h1d3a));
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'($urandom); expm[i] = mem[i]; end
    rst_n = 1'b0; start = 1'b0; start_addr = '0; periph_req = 1'b1;
    clr();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 events", {ev_start, ev_end, ev_buserr, ev_stop}, 0);

    // R2 R3 R11: plain word copy, start address with low bits set
    c = mk(16, 3, 3, 1, 1, 0, 0, 1, 1, 0);
    put_desc(32'h000, 32'h1, 32'h400, 32'h800, c);
    model(32'h400, 32'h800, c);
    clr(); kick(32'h00C); wait_idle("R2");
    cmp_mem("R2 copy");
    chk("R3 writes", nwr, 4);
    chk("R2 reads", nrd, 8);
    chk("R6 start count", n_start, 1);
    chk("R6 end count", n_end, 1);
    chk("R5 stop count", n_stop, 1);
    chk("R11 cur_src", cur_src, 32'h410);
    chk("R11 cur_trg", cur_trg, 32'h810);

    // R8 R3: byte reversal with tail elements
    c  = mk(7, 3, 0, 1, 1, 0, 0, 0, 0, 1);
    c2 = mk(5, 2, 0, 1, 1, 0, 0, 0, 1, 1);
    put_desc(32'h020, 32'h040, 32'h421, 32'h833, c);
    put_desc(32'h040, 32'h1, 32'h431, 32'h851, c2);
    model(32'h421, 32'h833, c); model(32'h431, 32'h851, c2);
    clr(); kick(32'h020); wait_idle("R8");
    cmp_mem("R8 reversed copy");
    chk("R3 tail writes", nwr, 5);
    chk("R6 end only where enabled", n_end, 1);

    // R4: zero-length descriptor
    c  = mk(0, 3, 0, 1, 1, 0, 0, 0, 1, 0);
    c2 = mk(8, 3, 0, 1, 1, 0, 0, 0, 1, 0);
    put_desc(32'h060, 32'h080, 32'h43c, 32'h860, c);
    put_desc(32'h080, 32'h1, 32'h440, 32'h870, c2);
    model(32'h440, 32'h870, c2);
    clr(); kick(32'h060); wait_idle("R4");
    chk("R4 writes", nwr, 2);
    chk("R4 end count", n_end, 2);
    cmp_mem("R4 copy");

    // R3: fixed target address
    c = mk(5, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    put_desc(32'h0A0, 32'h1, 32'h450, 32'h880, c);
    model(32'h450, 32'h880, c);
    clr(); kick(32'h0A0); wait_idle("R3");
    chk("R3 fixed target writes", nwr, 5);
    chk("R3 fixed cur_trg", cur_trg, 32'h880);
    chk("R11 cur_src advanced", cur_src, 32'h455);
    cmp_mem("R3 fixed target");

    // R7: target-paced bursts of 8 bytes
    c = mk(24, 3, 1, 1, 1, 0, 1, 0, 1, 0);
    put_desc(32'h0C0, 32'h1, 32'h460, 32'h890, c);
    model(32'h460, 32'h890, c);
    periph_req = 1'b0;
    clr(); kick(32'h0C0);
    repeat (60) @(negedge clk);
    chk("R7 no data before request", nwr, 0);
    periph_req = 1'b1;
    tw = 0;
    while (nwr < 1 && tw < 2000) begin @(negedge clk); tw++; end
    periph_req = 1'b0;
    repeat (100) @(negedge clk);
    chk("R7 one burst per request", nwr, 2);
    periph_req = 1'b1;
    wait_idle("R7");
    chk("R7 total writes", nwr, 6);
    cmp_mem("R7 copy");

    // R10: start while busy
    c  = mk(40, 1, 0, 1, 1, 0, 0, 0, 1, 0);
    c2 = mk(8, 3, 0, 1, 1, 0, 0, 0, 1, 0);
    put_desc(32'h0E0, 32'h1, 32'h480, 32'h8C0, c);
    put_desc(32'h100, 32'h1, 32'h4C0, 32'h900, c2);
    model(32'h480, 32'h8C0, c);
    clr(); kick(32'h0E0);
    repeat (10) @(negedge clk);
    kick(32'h100);
    wait_idle("R10");
    chk("R10 end count", n_end, 1);
    chk("R10 writes", nwr, 40);
    cmp_mem("R10 memory");

    // random chains
    for (int it = 0; it < 15; it++) begin
      int nd = $urandom_range(1, 3);
      exp_s = 0; exp_e = 0;
      for (int d = 0; d < nd; d++) begin
        s = 32'h500 + 32'($urandom_range(0, 32'h17F));
        t = 32'hA00 + 32'($urandom_range(0, 32'h3FF));
        c = mk($urandom_range(0, 40), $urandom_range(0, 3), $urandom_range(0, 3), 1, 1, 0, 0,
               1'($urandom), 1'($urandom), 1'($urandom));
        exp_s += int'(c[22]); exp_e += int'(c[21]);
        put_desc(32'h120 + 32'(d * 32), (d == nd - 1) ? 32'h1 : 32'h140 + 32'(d * 32), s, t, c);
        model(s, t, c);
      end
      clr(); kick(32'h120); wait_idle("R3 random");
      cmp_mem("R3 random copy");
      chk("R6 random start count", n_start, exp_s);
      chk("R6 random end count", n_end, exp_e);
      chk("R11 random cur_src", cur_src, s + 32'(c[12:0]));
      chk("R11 random cur_trg", cur_trg, t + 32'(c[12:0]));
    end

    // R5 R9: endless ring, then a bus error on a write
    c = mk(4, 3, 0, 1, 1, 0, 0, 0, 1, 0);
    put_desc(32'h180, 32'h1A0, 32'h700, 32'hF00, c);
    put_desc(32'h1A0, 32'h180, 32'h710, 32'hF10, c);
    model(32'h700, 32'hF00, c); model(32'h710, 32'hF10, c);
    clr(); kick(32'h180);
    tw = 0;
    while (n_end < 6 && tw < 5000) begin @(negedge clk); tw++; end
    chk("R5 ring keeps running", busy, 1);
    err_addr = 32'hF10; err_on = 1'b1;
    wait_idle("R9");
    err_on = 1'b0;
    chk("R9 bus error event", n_err, 1);
    chk("R5 ring never stops", n_stop, 0);
    ne = n_end; nw = nwr;
    repeat (30) @(negedge clk);
    chk("R9 no end after error", n_end, ne);
    chk("R9 no access after error", nwr, nw);
    chk("R9 request low", mem_req, 0);
    cmp_mem("R5 ring copy");

    chk("R12 request held", stable_bad, 0);
    summary();
    $finish;
  end
endmodule